// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is the control unit and register datapath of a small accumulator processor. Its control is hardwired. A timing counter steps through the slots t1 to t4. A one-hot opcode decoder is combined with the current cycle kind and the current slot to raise the register-transfer enables for that clock. The processor moves through four cycle kinds:

- **Fetch** reads the next instruction.
- **Indirect** resolves an indirect address.
- **Execute** carries out one of three instructions:
  - add-to-accumulator;
  - increment-memory-and-skip-when-zero;
  - branch-and-save-return.
- **Interrupt** saves the program counter and jumps to a handler.

Each cycle performs one group of transfers per clock. No group reads and writes the same register.

The block holds the program counter, memory address register, memory buffer register, instruction register and accumulator. It drives a plain synchronous memory port:

- The address always comes from the memory address register.
- The write data always comes from the memory buffer register.
- A read strobe and a write strobe select the operation.

Read data is expected to be combinational in the same clock. A write takes effect at the clock edge. The port has no handshake. The memory must answer every access in the cycle it is issued, so no back-pressure is possible. This is why there is no valid/ready pair on the port.

Program counter, accumulator, instruction register, cycle kind and timing slot are brought out for observation.

Instruction word, 16 bits:

| Bits | Field |
|------|-------|
| 15:13 | Opcode |
| 12 | Indirect flag |
| 11:0 | Address |

Opcode values:

| Code | Instruction |
|------|-------------|
| 000 | Add to accumulator |
| 001 | Increment and skip when zero |
| 010 | Branch and save return |
| 011 to 111 | No-op |

Top module: `uop_sequencer`

## Requirements
- R1: While reset is low, and right after its release, PC is 0, the accumulator is 0, IR is 0, the cycle kind is fetch (code 00) and the slot index is 0 (t1). The interrupt-enable flip-flop is set by reset.
- R2: Fetch takes three clocks. In t1, MAR gets PC. In t2, the read strobe is high with address MAR, MBR gets the read data and PC advances by one. In t3, IR gets MBR.
- R3: If bit 12 of the fetched word is 1, an indirect cycle (code 01) follows fetch. In it, MAR gets the IR address, MBR gets the memory word, and IR bits 11:0 are replaced by MBR bits 11:0. Execute follows. A clear bit 12 goes from fetch straight to execute (code 10).
- R4: Add (opcode 000) reads the word at the effective address in t2. In t3 it adds that word to the accumulator, modulo 2^16. Execute then ends.
- R5: Increment-and-skip (opcode 001) reads the word in t2, increments MBR in t3 and writes it back to the same address in t4. If the result is nonzero, PC is unchanged.
- R6: If the incremented word is 0, increment-and-skip also advances PC by one in t4. This skips the next instruction.
- R7: Branch-and-save (opcode 010) writes the return PC into the target address in t2. It then leaves PC at target+1 after t3.
- R8: When execute ends, the next cycle is interrupt (code 11) if the interrupt request and interrupt enable are both high. Otherwise the next cycle is fetch.
- R9: The interrupt cycle loads MBR with PC in t1. In t2 it loads MAR with SAVE_ADDR and PC with HANDLER_ADDR. In t3 it writes MBR to memory and then returns to fetch.
- R10: Entering the interrupt cycle clears interrupt enable. A request that stays high therefore causes no second interrupt.
- R11: Opcodes 011 to 111 finish execute in t1 with no memory access. PC, the accumulator and memory keep their values.
- R12: The read and write strobes are never high together.
- R13: The slot index returns to 0 in the first clock of every new cycle kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Read data, combinational from mem_addr |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, applied at the clock edge |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| cyc_o | output | 2 | Cycle kind: 00 fetch, 01 indirect, 10 execute, 11 interrupt |
| tstep_o | output | 2 | Timing slot index, 0 means t1 |

## Verification
A wrong slot or cycle decode shows up within one clock, because the strobes and the slot index are visible at the ports. A wrong MAR or MBR load shows up only at the next memory access, which is within two clocks, as a wrong address or wrong write data. A mistake in the IR address field, or a missed increment-and-skip, stays hidden until the following cycle kind. It then appears as a wrong PC or a wrong memory word at the end of that instruction, at most seven clocks later. A stuck interrupt-enable flip-flop appears only on the next execute boundary while the request is still high.

// File: rtl/uop_pkg.sv
package uop_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  // positions of instructions on the one-hot decoder output
  localparam int OP_ADD = 0;
  localparam int OP_ISZ = 1;
  localparam int OP_BSA = 2;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic ir_mbr;
    logic ir_adr_mbr;
    logic pc_inc;
    logic pc_inc_z;
    logic pc_ir;
    logic pc_hnd;
    logic acc_add;
    logic ien_clr;
    logic mem_rd;
    logic mem_wr;
  } ctl_t;
endpackage

// File: rtl/uop_tstep.sv
module uop_tstep #(
  parameter int NSTEP = 4,
  localparam int IW = $clog2(NSTEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [IW-1:0]    idx,
  output logic [NSTEP-1:0] t
);
  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else          idx <= idx + 1'b1;
  end

  for (genvar i = 0; i < NSTEP; i++) begin : g_slot
    assign t[i] = (idx == IW'(i));
  end
endmodule

// File: rtl/uop_opdec.sv
module uop_opdec #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] code,
  output logic [N-1:0] line
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign line[i] = (code == W'(i));
  end
endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl
  import uop_pkg::*;
#(
  parameter int NOPS = 8
) (
  input  cyc_e            cyc,
  input  logic [3:0]      t,
  input  logic [NOPS-1:0] op,
  input  logic            ind_bit,
  input  logic            irq,
  input  logic            ien,
  output ctl_t            c,
  output logic            end_cyc,
  output cyc_e            nxt
);
  logic mem_op, known;

  assign mem_op = op[OP_ADD] | op[OP_ISZ];
  assign known  = op[OP_ADD] | op[OP_ISZ] | op[OP_BSA];

  always_comb begin
    c       = '0;
    end_cyc = 1'b0;
    nxt     = CYC_FETCH;
    unique case (cyc)
      CYC_FETCH: begin
        c.mar_pc  = t[0];
        c.mbr_mem = t[1];
        c.mem_rd  = t[1];
        c.pc_inc  = t[1];
        c.ir_mbr  = t[2];
        end_cyc   = t[2];
        nxt       = ind_bit ? CYC_IND : CYC_EXEC;
      end
      CYC_IND: begin
        c.mar_ir     = t[0];
        c.mbr_mem    = t[1];
        c.mem_rd     = t[1];
        c.ir_adr_mbr = t[2];
        end_cyc      = t[2];
        nxt          = CYC_EXEC;
      end
      CYC_EXEC: begin
        c.mar_ir   = t[0] & known;
        c.mbr_pc   = t[0] & op[OP_BSA];
        c.mbr_mem  = t[1] & mem_op;
        c.mem_rd   = t[1] & mem_op;
        c.pc_ir    = t[1] & op[OP_BSA];
        c.acc_add  = t[2] & op[OP_ADD];
        c.mbr_inc  = t[2] & op[OP_ISZ];
        c.pc_inc   = t[2] & op[OP_BSA];
        c.pc_inc_z = t[3] & op[OP_ISZ];
        c.mem_wr   = (t[1] & op[OP_BSA]) | (t[3] & op[OP_ISZ]);
        end_cyc    = (t[2] & (op[OP_ADD] | op[OP_BSA])) | (t[3] & op[OP_ISZ])
                   | (t[0] & ~known);
        nxt        = (irq && ien) ? CYC_INT : CYC_FETCH;
        c.ien_clr  = end_cyc & irq & ien;
      end
      CYC_INT: begin
        c.mbr_pc   = t[0];
        c.mar_save = t[1];
        c.pc_hnd   = t[1];
        c.mem_wr   = t[2];
        end_cyc    = t[2];
        nxt        = CYC_FETCH;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h3F0,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h3F1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [1:0]        cyc_o,
  output logic [1:0]        tstep_o
);
  localparam int NSTEP = 4;
  localparam int NOPS  = 1 << OPC_W;
  localparam int IND_B = ADDR_W;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir, acc;
  logic              ien;
  cyc_e              cyc, nxt;
  logic              end_cyc;
  logic [NSTEP-1:0]  t;
  logic [NOPS-1:0]   op;
  ctl_t              c;

  uop_tstep #(.NSTEP(NSTEP)) u_tstep (
    .clk(clk), .rst_n(rst_n), .clr(end_cyc), .idx(tstep_o), .t(t)
  );

  uop_opdec #(.W(OPC_W)) u_opdec (
    .code(ir[DATA_W-1 -: OPC_W]), .line(op)
  );

  uop_ctrl #(.NOPS(NOPS)) u_ctrl (
    .cyc(cyc), .t(t), .op(op), .ind_bit(mbr[IND_B]), .irq(irq), .ien(ien),
    .c(c), .end_cyc(end_cyc), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      ien <= 1'b1;
      cyc <= CYC_FETCH;
    end else begin
      if (c.mar_pc)     mar <= pc;
      if (c.mar_ir)     mar <= ir[ADDR_W-1:0];
      if (c.mar_save)   mar <= SAVE_ADDR;
      if (c.mbr_mem)    mbr <= mem_rdata;
      if (c.mbr_pc)     mbr <= {{(DATA_W-ADDR_W){1'b0}}, pc};
      if (c.mbr_inc)    mbr <= mbr + 1'b1;
      if (c.ir_mbr)     ir <= mbr;
      if (c.ir_adr_mbr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
      if (c.pc_ir)      pc <= ir[ADDR_W-1:0];
      else if (c.pc_hnd) pc <= HANDLER_ADDR;
      else if (c.pc_inc || (c.pc_inc_z && mbr == '0)) pc <= pc + 1'b1;
      if (c.acc_add)    acc <= acc + mbr;
      if (c.ien_clr)    ien <= 1'b0;
      if (end_cyc)      cyc <= nxt;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = c.mem_rd;
  assign mem_wr    = c.mem_wr;
  assign pc_o      = pc;
  assign acc_o     = acc;
  assign ir_o      = ir;
  assign cyc_o     = cyc;
endmodule

// File: rtl/uop_sequencer_chk.sv
module uop_sequencer_chk #(
  parameter logic [11:0] HANDLER_ADDR = 12'h3F1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cyc,
  input logic [1:0]  tstep,
  input logic [11:0] pc,
  input logic        mem_rd,
  input logic        mem_wr
);
  assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_slot_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != $past(cyc)) |-> (tstep == 2'd0));

  assert_fetch_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b00 && tstep == 2'd1) |-> mem_rd);

  assert_fetch_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b00 && tstep == 2'd1) |=> (pc == $past(pc) + 12'd1));

  assert_int_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b11 && tstep == 2'd0) |-> ($past(cyc) == 2'b10));

  assert_handler_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b11 && tstep == 2'd1) |=> (pc == HANDLER_ADDR));
endmodule

bind uop_sequencer uop_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(cyc_o), .tstep(tstep_o), .pc(pc_o),
  .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/uop_sequencer_bench.sv
module uop_sequencer_bench;
  localparam logic [11:0] SAVE = 12'h3F0;
  localparam logic [11:0] HND  = 12'h3F1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata, mem_wdata, acc_o, ir_o;
  logic [11:0] mem_addr, pc_o;
  logic        mem_rd, mem_wr;
  logic [1:0]  cyc_o, tstep_o;
  logic [15:0] mem [1024];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          over  = 1'b0;

  always #2.5 clk = ~clk;

  uop_sequencer u_uop_sequencer (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .pc_o(pc_o), .acc_o(acc_o), .ir_o(ir_o),
    .cyc_o(cyc_o), .tstep_o(tstep_o)
  );

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
  endtask

  task automatic restart();
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    step(2);
    chk("R1 pc", {4'h0, pc_o}, 16'h0);
    chk("R1 acc", acc_o, 16'h0);
    chk("R1 ir", ir_o, 16'h0);
    chk("R1 cyc", {14'h0, cyc_o}, 16'h0);
    chk("R1 slot", {14'h0, tstep_o}, 16'h0);
  endtask

  task automatic t_fetch();
    clear_mem();
    mem[0] = 16'h0100; mem[12'h100] = 16'h0005;
    restart();
    step(1);
    chk("R2 rd strobe t2", {15'h0, mem_rd}, 16'h1);
    chk("R2 rd addr t2", {4'h0, mem_addr}, 16'h0);
    step(1);
    chk("R2 pc after t2", {4'h0, pc_o}, 16'h1);
    step(1);
    chk("R2 ir loaded", ir_o, 16'h0100);
    chk("R3 direct to exec", {14'h0, cyc_o}, 16'h2);
    chk("R13 slot restart", {14'h0, tstep_o}, 16'h0);
  endtask

  task automatic t_add();
    clear_mem();
    mem[0] = 16'h0100; mem[1] = 16'h0101;
    mem[12'h100] = 16'h0005; mem[12'h101] = 16'hFFFE;
    restart();
    step(6);
    chk("R4 add first", acc_o, 16'h0005);
    chk("R8 fetch after exec", {14'h0, cyc_o}, 16'h0);
    step(6);
    chk("R4 add wraps", acc_o, 16'h0003);
    chk("R4 pc", {4'h0, pc_o}, 16'h2);
  endtask

  task automatic t_indirect();
    clear_mem();
    mem[0] = 16'h1200; mem[12'h200] = 16'h0105; mem[12'h105] = 16'h0009;
    restart();
    step(3);
    chk("R3 indirect cycle", {14'h0, cyc_o}, 16'h1);
    step(3);
    chk("R3 ir address replaced", ir_o, 16'h1105);
    chk("R3 exec after indirect", {14'h0, cyc_o}, 16'h2);
    step(3);
    chk("R3 operand via pointer", acc_o, 16'h0009);
  endtask

  task automatic t_isz(input logic [15:0] init, input logic [15:0] exp_w,
                       input logic [11:0] exp_pc, input string req);
    clear_mem();
    mem[0] = 16'h2110; mem[12'h110] = init;
    restart();
    step(7);
    chk(req, mem[12'h110], exp_w);
    chk(req, {4'h0, pc_o}, {4'h0, exp_pc});
    chk(req, {14'h0, cyc_o}, 16'h0);
  endtask

  task automatic t_bsa();
    clear_mem();
    mem[0] = 16'h4300;
    restart();
    step(6);
    chk("R7 saved return", mem[12'h300], 16'h0001);
    chk("R7 pc target+1", {4'h0, pc_o}, 16'h0301);
  endtask

  task automatic t_nop();
    clear_mem();
    mem[0] = 16'hE100; mem[12'h100] = 16'h0077;
    restart();
    step(3);
    chk("R11 nop no read", {15'h0, mem_rd}, 16'h0);
    step(1);
    chk("R11 nop done in t1", {14'h0, cyc_o}, 16'h0);
    chk("R11 pc", {4'h0, pc_o}, 16'h1);
    chk("R11 acc", acc_o, 16'h0);
    chk("R11 mem", mem[12'h100], 16'h0077);
  endtask

  task automatic t_irq();
    clear_mem();
    mem[0] = 16'h0100; mem[12'h100] = 16'h0005; mem[HND[9:0]] = 16'h0100;
    irq = 1'b1;
    restart();
    step(6);
    chk("R8 enter interrupt", {14'h0, cyc_o}, 16'h3);
    step(3);
    chk("R9 saved pc", mem[SAVE[9:0]], 16'h0001);
    chk("R9 handler pc", {4'h0, pc_o}, {4'h0, HND});
    chk("R9 back to fetch", {14'h0, cyc_o}, 16'h0);
    step(6);
    chk("R10 no second interrupt", {14'h0, cyc_o}, 16'h0);
    chk("R10 handler ran", acc_o, 16'h000A);
    chk("R10 pc", {4'h0, pc_o}, {4'h0, HND + 12'd1});
    irq = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!over) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fetch();
    t_add();
    t_indirect();
    t_isz(16'h0003, 16'h0004, 12'h001, "R5 isz no skip");
    t_isz(16'hFFFF, 16'h0000, 12'h002, "R6 isz skip");
    t_bsa();
    t_nop();
    t_irq();
    over = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule